// File: doc/BRIEF.md
# Rectangular Region Claim Node

This block sits beside each processing element of a two-dimensional mesh and lets a program reserve a rectangle of elements without a central manager. A claim names a direction pair, a row count and a column count. The element that receives it takes itself and splits the rest of the work. If it lies on the leading row, it passes a claim for the remaining columns to its horizontal neighbour and, in the same cycle, a column-only claim for the remaining rows to its vertical neighbour. Columns are therefore explored side by side, and the time to fill a rectangle grows with rows plus columns, not with their product.

Each element answers upstream once every branch it opened has answered. It accepts only when all its branches accepted. A refusal anywhere unwinds: the refusing branch drops its own claim, and the element sends a release to every branch that had already accepted before it reports the refusal. A release that comes down from upstream, or from the local element if it started the claim, frees the element and is passed on to all its branches.

Every neighbour link carries one message word per cycle. The local element starts a claim through a start strobe, frees it with a release strobe, and sees the outcome on a done/granted pair.

Top module: `rect_claim_node`

## Requirements
- R1: After reset every outgoing message word is zero (no message), `claimed_o` is 0 and `done_o`/`granted_o` are 0.
- R2: A message word holds kind in bits [2:0] (0 none, 1 claim, 2 accept, 3 refuse, 4 release), the column-only flag in bit 3, the direction in bits [5:4] (bit 4 set means west and clear means east; bit 5 set means north and clear means south), the row count in bits [9:6] and the column count in bits [13:10]. Accept, refuse and release words carry zero in every other field. Link index order is north 0, east 1, south 2, west 3, with the local element last.
- R3: A free, idle element that receives a leading-row claim with rows > 1 and columns > 1 takes the claim and, in one cycle, sends a leading-row claim with columns minus one on its horizontal link and a column-only claim with rows minus one (same columns) on its vertical link.
- R4: A column-only claim never produces a horizontal claim. A claim that needs no branch is accepted straight back on the link it came from.
- R5: An element that opened branches sends accept upstream only in the cycle after the last of those branches has accepted.
- R6: If any branch refuses, the element sends refuse upstream, sends release to each branch that accepted, and clears its claim.
- R7: An element that is busy, or already holds or is building a claim, refuses every new claim on the link it arrived on and keeps its state.
- R8: A claim with a zero row count or a zero column count is refused.
- R9: A release from upstream to a holding element is passed to every branch it opened and clears the claim. A release at any other time changes nothing.
- R10: A local start acts as a claim arriving on the local port. Its outcome is a one-cycle `done_o` pulse, with `granted_o` set on accept. A local release frees a claim the local element started.
- R11: When several claims arrive in the same cycle, the lowest link index wins and the others are refused. A refusal that collides with a forwarded claim on the same link is sent one cycle later.
- R12: Each hop takes two cycles: a word driven in one cycle produces this element's reply two clock edges later. No other output word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_busy_i | input | 1 | Local element already runs other work |
| start_i | input | 1 | Local request to claim a rectangle |
| start_dir_i | input | 2 | Direction pair of the local request |
| start_rows_i | input | 4 | Row count of the local request |
| start_cols_i | input | 4 | Column count of the local request |
| release_i | input | 1 | Local release of a claim it started |
| rx_n_i | input | 14 | Message word from the north neighbour |
| rx_e_i | input | 14 | Message word from the east neighbour |
| rx_s_i | input | 14 | Message word from the south neighbour |
| rx_w_i | input | 14 | Message word from the west neighbour |
| tx_n_o | output | 14 | Message word to the north neighbour |
| tx_e_o | output | 14 | Message word to the east neighbour |
| tx_s_o | output | 14 | Message word to the south neighbour |
| tx_w_o | output | 14 | Message word to the west neighbour |
| claimed_o | output | 1 | Element is building or holding a claim |
| done_o | output | 1 | Outcome of a local request is ready |
| granted_o | output | 1 | Local request was accepted |

## Verification
The assertions assume the neighbours follow the protocol. A release comes only from the link that owns the claim, and only after that link was sent an accept. Accept and refuse words come only from links this element actually invaded, once per branch. The stimulus acts as a set of well-behaved neighbours: it answers each forwarded claim with one reply, releases only held claims, and keeps the busy input steady across the cycle in which a claim is decided. Stray words, such as a release to a free element, are sent only where the requirements define them as having no effect.

// File: rtl/rcn_pkg.sv
package rcn_pkg;
    localparam int DIM_W  = 4;
    localparam int NPORT  = 5;
    localparam int PIDX_W = $clog2(NPORT);
    localparam int KIND_W = 3;
    localparam int MSG_W  = KIND_W + 1 + 2 + 2 * DIM_W;
    localparam logic [PIDX_W-1:0] LINK_N   = PIDX_W'(0);
    localparam logic [PIDX_W-1:0] LINK_E   = PIDX_W'(1);
    localparam logic [PIDX_W-1:0] LINK_S   = PIDX_W'(2);
    localparam logic [PIDX_W-1:0] LINK_W   = PIDX_W'(3);
    localparam logic [PIDX_W-1:0] LINK_LOC = PIDX_W'(4);

    typedef enum logic [KIND_W-1:0] {
        K_NONE    = 3'd0,
        K_CLAIM   = 3'd1,
        K_ACCEPT  = 3'd2,
        K_REFUSE  = 3'd3,
        K_RELEASE = 3'd4
    } kind_e;

    typedef struct packed {
        logic [DIM_W-1:0] cols;
        logic [DIM_W-1:0] rows;
        logic [1:0]       dir;
        logic             col_only;
        kind_e            kind;
    } msg_t;

    typedef enum logic [1:0] {
        ST_FREE,
        ST_WAIT,
        ST_HELD
    } node_st_e;

    function automatic logic [PIDX_W-1:0] horiz_link(input logic [1:0] dir);
        return dir[0] ? LINK_W : LINK_E;
    endfunction

    function automatic logic [PIDX_W-1:0] vert_link(input logic [1:0] dir);
        return dir[1] ? LINK_N : LINK_S;
    endfunction

    function automatic msg_t bare_msg(input kind_e k);
        msg_t m;
        m      = '0;
        m.kind = k;
        return m;
    endfunction
endpackage

// File: rtl/rcn_rx_stage.sv
module rcn_rx_stage
    import rcn_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORT-1:0][MSG_W-1:0] raw_i,
    output msg_t                        rx_o [NPORT],
    output logic                        any_claim_o
);
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (rst || raw_i[p][KIND_W-1:0] > KIND_W'(K_RELEASE)) begin
                rx_o[p] <= '0;
            end else begin
                rx_o[p] <= msg_t'(raw_i[p]);
            end
        end
    end

    always_comb begin
        any_claim_o = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (rx_o[p].kind == K_CLAIM) any_claim_o = 1'b1;
        end
    end
endmodule

// File: rtl/rcn_pick.sv
module rcn_pick
    import rcn_pkg::*;
(
    input  msg_t              rx_i [NPORT],
    output logic [NPORT-1:0]  claim_mask_o,
    output logic              win_v_o,
    output logic [PIDX_W-1:0] win_o
);
    always_comb begin
        claim_mask_o = '0;
        win_v_o      = 1'b0;
        win_o        = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (rx_i[p].kind == K_CLAIM) begin
                claim_mask_o[p] = 1'b1;
                win_v_o         = 1'b1;
                win_o           = PIDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/rcn_fsm.sv
module rcn_fsm
    import rcn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  msg_t              rx_i [NPORT],
    input  logic [NPORT-1:0]  claim_mask_i,
    input  logic              win_v_i,
    input  logic [PIDX_W-1:0] win_i,
    output logic [NPORT-1:0]  out_v_o,
    output msg_t              out_m_o [NPORT],
    output logic [NPORT-1:0]  refuse_req_o,
    output logic              claimed_o
);
    node_st_e          st_q, st_n;
    logic [PIDX_W-1:0] up_q, up_n;
    logic [PIDX_W-1:0] hl_q, hl_n;
    logic [PIDX_W-1:0] vl_q, vl_n;
    logic              use_h_q, use_h_n, use_v_q, use_v_n;
    logic              pend_h_q, pend_h_n, pend_v_q, pend_v_n;
    logic              ok_h_q, ok_h_n, ok_v_q, ok_v_n;
    logic              fail_q, fail_n;

    msg_t              in_m;
    logic [PIDX_W-1:0] h_l, v_l;
    logic              need_h, need_v;
    kind_e             h_kind, v_kind;

    always_comb begin
        st_n     = st_q;
        up_n     = up_q;
        hl_n     = hl_q;
        vl_n     = vl_q;
        use_h_n  = use_h_q;
        use_v_n  = use_v_q;
        pend_h_n = pend_h_q;
        pend_v_n = pend_v_q;
        ok_h_n   = ok_h_q;
        ok_v_n   = ok_v_q;
        fail_n   = fail_q;
        out_v_o  = '0;
        for (int p = 0; p < NPORT; p++) out_m_o[p] = '0;
        refuse_req_o = claim_mask_i;
        in_m   = rx_i[win_i];
        h_l    = horiz_link(in_m.dir);
        v_l    = vert_link(in_m.dir);
        need_h = !in_m.col_only && (in_m.cols > DIM_W'(1));
        need_v = in_m.rows > DIM_W'(1);
        h_kind = rx_i[hl_q].kind;
        v_kind = rx_i[vl_q].kind;

        case (st_q)
            ST_FREE: begin
                if (win_v_i && !busy_i && in_m.rows != '0 && in_m.cols != '0) begin
                    refuse_req_o[win_i] = 1'b0;
                    up_n     = win_i;
                    hl_n     = h_l;
                    vl_n     = v_l;
                    use_h_n  = need_h;
                    use_v_n  = need_v;
                    pend_h_n = need_h;
                    pend_v_n = need_v;
                    ok_h_n   = 1'b0;
                    ok_v_n   = 1'b0;
                    fail_n   = 1'b0;
                    if (need_h) begin
                        out_v_o[h_l]          = 1'b1;
                        out_m_o[h_l].kind     = K_CLAIM;
                        out_m_o[h_l].dir      = in_m.dir;
                        out_m_o[h_l].col_only = 1'b0;
                        out_m_o[h_l].rows     = in_m.rows;
                        out_m_o[h_l].cols     = in_m.cols - DIM_W'(1);
                    end
                    if (need_v) begin
                        out_v_o[v_l]          = 1'b1;
                        out_m_o[v_l].kind     = K_CLAIM;
                        out_m_o[v_l].dir      = in_m.dir;
                        out_m_o[v_l].col_only = 1'b1;
                        out_m_o[v_l].rows     = in_m.rows - DIM_W'(1);
                        out_m_o[v_l].cols     = in_m.cols;
                    end
                    if (need_h || need_v) begin
                        st_n = ST_WAIT;
                    end else begin
                        st_n           = ST_HELD;
                        out_v_o[win_i] = 1'b1;
                        out_m_o[win_i] = bare_msg(K_ACCEPT);
                    end
                end
            end
            ST_WAIT: begin
                if (pend_h_q && h_kind == K_ACCEPT) begin
                    pend_h_n = 1'b0;
                    ok_h_n   = 1'b1;
                end else if (pend_h_q && h_kind == K_REFUSE) begin
                    pend_h_n = 1'b0;
                    fail_n   = 1'b1;
                end
                if (pend_v_q && v_kind == K_ACCEPT) begin
                    pend_v_n = 1'b0;
                    ok_v_n   = 1'b1;
                end else if (pend_v_q && v_kind == K_REFUSE) begin
                    pend_v_n = 1'b0;
                    fail_n   = 1'b1;
                end
                if (!pend_h_n && !pend_v_n) begin
                    out_v_o[up_q] = 1'b1;
                    if (fail_n) begin
                        st_n          = ST_FREE;
                        out_m_o[up_q] = bare_msg(K_REFUSE);
                        if (ok_h_n) begin
                            out_v_o[hl_q] = 1'b1;
                            out_m_o[hl_q] = bare_msg(K_RELEASE);
                        end
                        if (ok_v_n) begin
                            out_v_o[vl_q] = 1'b1;
                            out_m_o[vl_q] = bare_msg(K_RELEASE);
                        end
                    end else begin
                        st_n          = ST_HELD;
                        out_m_o[up_q] = bare_msg(K_ACCEPT);
                    end
                end
            end
            ST_HELD: begin
                if (rx_i[up_q].kind == K_RELEASE) begin
                    st_n = ST_FREE;
                    if (use_h_q) begin
                        out_v_o[hl_q] = 1'b1;
                        out_m_o[hl_q] = bare_msg(K_RELEASE);
                    end
                    if (use_v_q) begin
                        out_v_o[vl_q] = 1'b1;
                        out_m_o[vl_q] = bare_msg(K_RELEASE);
                    end
                end
            end
            default: st_n = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_FREE;
            up_q     <= '0;
            hl_q     <= '0;
            vl_q     <= '0;
            use_h_q  <= 1'b0;
            use_v_q  <= 1'b0;
            pend_h_q <= 1'b0;
            pend_v_q <= 1'b0;
            ok_h_q   <= 1'b0;
            ok_v_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            st_q     <= st_n;
            up_q     <= up_n;
            hl_q     <= hl_n;
            vl_q     <= vl_n;
            use_h_q  <= use_h_n;
            use_v_q  <= use_v_n;
            pend_h_q <= pend_h_n;
            pend_v_q <= pend_v_n;
            ok_h_q   <= ok_h_n;
            ok_v_q   <= ok_v_n;
            fail_q   <= fail_n;
        end
    end

    assign claimed_o = (st_q != ST_FREE);
endmodule

// File: rtl/rcn_tx_stage.sv
module rcn_tx_stage
    import rcn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] out_v_i,
    input  msg_t             out_m_i [NPORT],
    input  logic [NPORT-1:0] refuse_req_i,
    output msg_t             tx_o [NPORT]
);
    for (genvar p = 0; p < NPORT; p++) begin : g_link
        logic owed_q;
        logic owed_n;
        assign owed_n = owed_q | refuse_req_i[p];
        always_ff @(posedge clk) begin
            if (rst) begin
                owed_q  <= 1'b0;
                tx_o[p] <= '0;
            end else if (out_v_i[p]) begin
                owed_q  <= owed_n;
                tx_o[p] <= out_m_i[p];
            end else if (owed_n) begin
                owed_q  <= 1'b0;
                tx_o[p] <= bare_msg(K_REFUSE);
            end else begin
                owed_q  <= 1'b0;
                tx_o[p] <= '0;
            end
        end
    end
endmodule

// File: rtl/rect_claim_node.sv
module rect_claim_node
    import rcn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pe_busy_i,
    input  logic             start_i,
    input  logic [1:0]       start_dir_i,
    input  logic [DIM_W-1:0] start_rows_i,
    input  logic [DIM_W-1:0] start_cols_i,
    input  logic             release_i,
    input  logic [MSG_W-1:0] rx_n_i,
    input  logic [MSG_W-1:0] rx_e_i,
    input  logic [MSG_W-1:0] rx_s_i,
    input  logic [MSG_W-1:0] rx_w_i,
    output logic [MSG_W-1:0] tx_n_o,
    output logic [MSG_W-1:0] tx_e_o,
    output logic [MSG_W-1:0] tx_s_o,
    output logic [MSG_W-1:0] tx_w_o,
    output logic             claimed_o,
    output logic             done_o,
    output logic             granted_o
);
    logic [NPORT-1:0][MSG_W-1:0] raw;
    msg_t                        loc_m;
    msg_t                        rx [NPORT];
    msg_t                        tx [NPORT];
    msg_t                        out_m [NPORT];
    logic                        rx_any_claim;
    logic [NPORT-1:0]            claim_mask;
    logic                        win_v;
    logic [PIDX_W-1:0]           win;
    logic [NPORT-1:0]            out_v;
    logic [NPORT-1:0]            refuse_req;

    always_comb begin
        loc_m = '0;
        if (start_i) begin
            loc_m.kind = K_CLAIM;
            loc_m.dir  = start_dir_i;
            loc_m.rows = start_rows_i;
            loc_m.cols = start_cols_i;
        end else if (release_i) begin
            loc_m.kind = K_RELEASE;
        end
    end

    assign raw[LINK_N]   = rx_n_i;
    assign raw[LINK_E]   = rx_e_i;
    assign raw[LINK_S]   = rx_s_i;
    assign raw[LINK_W]   = rx_w_i;
    assign raw[LINK_LOC] = loc_m;

    rcn_rx_stage u_rx (
        .clk         (clk),
        .rst         (rst),
        .raw_i       (raw),
        .rx_o        (rx),
        .any_claim_o (rx_any_claim)
    );

    rcn_pick u_pick (
        .rx_i         (rx),
        .claim_mask_o (claim_mask),
        .win_v_o      (win_v),
        .win_o        (win)
    );

    rcn_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .busy_i       (pe_busy_i),
        .rx_i         (rx),
        .claim_mask_i (claim_mask),
        .win_v_i      (win_v),
        .win_i        (win),
        .out_v_o      (out_v),
        .out_m_o      (out_m),
        .refuse_req_o (refuse_req),
        .claimed_o    (claimed_o)
    );

    rcn_tx_stage u_tx (
        .clk          (clk),
        .rst          (rst),
        .out_v_i      (out_v),
        .out_m_i      (out_m),
        .refuse_req_i (refuse_req),
        .tx_o         (tx)
    );

    assign tx_n_o    = tx[LINK_N];
    assign tx_e_o    = tx[LINK_E];
    assign tx_s_o    = tx[LINK_S];
    assign tx_w_o    = tx[LINK_W];
    assign done_o    = (tx[LINK_LOC].kind == K_ACCEPT) || (tx[LINK_LOC].kind == K_REFUSE);
    assign granted_o = (tx[LINK_LOC].kind == K_ACCEPT);
endmodule

// File: rtl/rcn_checker.sv
module rcn_checker
    import rcn_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pe_busy_i,
    input logic             claimed_o,
    input logic             granted_o,
    input logic             rx_any_claim,
    input logic [MSG_W-1:0] tx_n_o,
    input logic [MSG_W-1:0] tx_e_o,
    input logic [MSG_W-1:0] tx_s_o,
    input logic [MSG_W-1:0] tx_w_o
);
    logic any_accept_out;
    logic any_release_out;

    assign any_accept_out =
        (tx_n_o[KIND_W-1:0] == KIND_W'(K_ACCEPT)) || (tx_e_o[KIND_W-1:0] == KIND_W'(K_ACCEPT)) ||
        (tx_s_o[KIND_W-1:0] == KIND_W'(K_ACCEPT)) || (tx_w_o[KIND_W-1:0] == KIND_W'(K_ACCEPT));
    assign any_release_out =
        (tx_n_o[KIND_W-1:0] == KIND_W'(K_RELEASE)) || (tx_e_o[KIND_W-1:0] == KIND_W'(K_RELEASE)) ||
        (tx_s_o[KIND_W-1:0] == KIND_W'(K_RELEASE)) || (tx_w_o[KIND_W-1:0] == KIND_W'(K_RELEASE));

    a_r3_claim_follows_request: assert property (@(posedge clk) disable iff (rst)
        $rose(claimed_o) |-> $past(rx_any_claim));

    a_r5_accept_only_when_held: assert property (@(posedge clk) disable iff (rst)
        (any_accept_out || granted_o) |-> claimed_o);

    a_r7_busy_blocks_claim: assert property (@(posedge clk) disable iff (rst)
        (pe_busy_i && !claimed_o) |=> !claimed_o);

    a_r9_release_drops_claim: assert property (@(posedge clk) disable iff (rst)
        any_release_out |-> (!claimed_o && $past(claimed_o)));
endmodule

bind rect_claim_node rcn_checker u_rcn_checker (
    .clk          (clk),
    .rst          (rst),
    .pe_busy_i    (pe_busy_i),
    .claimed_o    (claimed_o),
    .granted_o    (granted_o),
    .rx_any_claim (rx_any_claim),
    .tx_n_o       (tx_n_o),
    .tx_e_o       (tx_e_o),
    .tx_s_o       (tx_s_o),
    .tx_w_o       (tx_w_o)
);

// File: tb/rect_claim_node_test.sv
module rect_claim_node_test;
    localparam int MW = rcn_pkg::MSG_W;
    localparam int N_ = 0, E_ = 1, S_ = 2, W_ = 3, L_ = 4;
    localparam int CLM = 1, ACC = 2, REF = 3, REL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          busy = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    s_dir = '0;
    logic [3:0]    s_rows = '0;
    logic [3:0]    s_cols = '0;
    logic          rel = 1'b0;
    logic [MW-1:0] rxv [4];
    logic [MW-1:0] txv [4];
    logic          claimed, done, granted;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    int cur_clm = 0;
    logic [MW-1:0] exp_msg [int];
    string         exp_tag [int];
    int            exp_clm [int];
    string         clm_tag [int];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rect_claim_node uut (
        .clk(clk), .rst(rst), .pe_busy_i(busy),
        .start_i(start), .start_dir_i(s_dir), .start_rows_i(s_rows), .start_cols_i(s_cols),
        .release_i(rel),
        .rx_n_i(rxv[0]), .rx_e_i(rxv[1]), .rx_s_i(rxv[2]), .rx_w_i(rxv[3]),
        .tx_n_o(txv[0]), .tx_e_o(txv[1]), .tx_s_o(txv[2]), .tx_w_o(txv[3]),
        .claimed_o(claimed), .done_o(done), .granted_o(granted)
    );

    function automatic logic [MW-1:0] mk(int kind, int col_only, int dir, int rows, int cols);
        return {4'(cols), 4'(rows), 2'(dir), 1'(col_only), 3'(kind)};
    endfunction

    task automatic exp_at(int dc, int p, logic [MW-1:0] m, string tag);
        exp_msg[(cyc + dc) * 8 + p] = m;
        exp_tag[(cyc + dc) * 8 + p] = tag;
    endtask

    task automatic clm_at(int dc, int v, string tag);
        exp_clm[cyc + dc] = v;
        clm_tag[cyc + dc] = tag;
    endtask

    task automatic tick();
        @(negedge clk);
        for (int p = 0; p < 4; p++) rxv[p] = '0;
        start = 1'b0;
        rel   = 1'b0;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) tick();
    endtask

    // reference comparison on every cycle
    always @(negedge clk) begin
        if (mon_on) begin
            for (int p = 0; p < 5; p++) begin
                int            k;
                logic [MW-1:0] e;
                string         tg;
                k  = cyc * 8 + p;
                e  = exp_msg.exists(k) ? exp_msg[k] : '0;
                tg = exp_tag.exists(k) ? exp_tag[k] : "R12";
                n_tests++;
                if (p < 4) begin
                    if (txv[p] !== e) begin
                        n_fail++;
                        $display("FAIL %s: link %0d cycle %0d actual %h expected %h", tg, p, cyc, txv[p], e);
                    end
                end else begin
                    if (done !== (e[2:0] == 3'(ACC) || e[2:0] == 3'(REF)) || granted !== (e[2:0] == 3'(ACC))) begin
                        n_fail++;
                        $display("FAIL %s: local cycle %0d actual done=%0b granted=%0b expected kind %0d",
                                 tg, cyc, done, granted, e[2:0]);
                    end
                end
            end
            if (exp_clm.exists(cyc)) cur_clm = exp_clm[cyc];
            n_tests++;
            if (claimed !== 1'(cur_clm)) begin
                n_fail++;
                $display("FAIL %s: claimed cycle %0d actual %0b expected %0d",
                         clm_tag.exists(cyc) ? clm_tag[cyc] : "R12", cyc, claimed, cur_clm);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12: watchdog expired at cycle %0d actual running expected finished", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t;
        for (int p = 0; p < 4; p++) rxv[p] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_tests++;
        if (txv[0] !== '0 || txv[1] !== '0 || txv[2] !== '0 || txv[3] !== '0 ||
            claimed !== 1'b0 || done !== 1'b0 || granted !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: after reset actual claimed=%0b done=%0b expected all zero", claimed, done);
        end
        mon_on = 1'b1;
        tick();

        // R3, R2, R12: leading-row claim south-east, 3 rows 5 cols from west
        t = cyc;
        rxv[W_] = mk(CLM, 0, 0, 3, 5);
        exp_at(2, E_, mk(CLM, 0, 0, 3, 4), "R3");
        exp_at(2, S_, mk(CLM, 1, 0, 2, 5), "R3");
        clm_at(2, 1, "R3");
        wait_to(t + 4);
        rxv[E_] = mk(ACC, 0, 0, 0, 0);
        exp_at(2, W_, '0, "R5");           // one branch still open
        wait_to(t + 6);
        rxv[S_] = mk(ACC, 0, 0, 0, 0);
        exp_at(2, W_, mk(ACC, 0, 0, 0, 0), "R5");
        wait_to(t + 10);

        // R7: held element refuses a new claim
        rxv[N_] = mk(CLM, 1, 0, 1, 1);
        exp_at(2, N_, mk(REF, 0, 0, 0, 0), "R7");
        tick(); wait_to(cyc + 3);

        // R9: release from owner forwards to both branches
        rxv[W_] = mk(REL, 0, 0, 0, 0);
        exp_at(2, E_, mk(REL, 0, 0, 0, 0), "R9");
        exp_at(2, S_, mk(REL, 0, 0, 0, 0), "R9");
        clm_at(2, 0, "R9");
        tick(); wait_to(cyc + 3);

        // R9: stray release and accept while free do nothing
        rxv[W_] = mk(REL, 0, 0, 0, 0);
        rxv[S_] = mk(ACC, 0, 0, 0, 0);
        exp_at(2, E_, '0, "R9");
        exp_at(2, W_, '0, "R9");
        clm_at(2, 0, "R9");
        tick(); wait_to(cyc + 3);

        // R4: column element with one row accepts at once
        rxv[N_] = mk(CLM, 1, 0, 1, 1);
        exp_at(2, N_, mk(ACC, 0, 0, 0, 0), "R4");
        clm_at(2, 1, "R4");
        tick(); wait_to(cyc + 3);
        rxv[N_] = mk(REL, 0, 0, 0, 0);
        exp_at(2, E_, '0, "R4");
        exp_at(2, S_, '0, "R4");
        clm_at(2, 0, "R9");
        tick(); wait_to(cyc + 3);

        // R4, R6: column element forwards only down; a refusal unwinds it
        t = cyc;
        rxv[N_] = mk(CLM, 1, 0, 3, 5);
        exp_at(2, S_, mk(CLM, 1, 0, 2, 5), "R4");
        exp_at(2, E_, '0, "R4");
        clm_at(2, 1, "R4");
        wait_to(t + 4);
        rxv[S_] = mk(REF, 0, 0, 0, 0);
        exp_at(2, N_, mk(REF, 0, 0, 0, 0), "R6");
        exp_at(2, S_, '0, "R6");
        clm_at(2, 0, "R6");
        tick(); wait_to(cyc + 3);

        // R6: horizontal refusal, vertical accept -> release vertical, refuse up
        t = cyc;
        rxv[W_] = mk(CLM, 0, 0, 2, 2);
        exp_at(2, E_, mk(CLM, 0, 0, 2, 1), "R3");
        exp_at(2, S_, mk(CLM, 1, 0, 1, 2), "R3");
        clm_at(2, 1, "R3");
        wait_to(t + 4);
        rxv[S_] = mk(ACC, 0, 0, 0, 0);
        rxv[E_] = mk(REF, 0, 0, 0, 0);
        exp_at(2, W_, mk(REF, 0, 0, 0, 0), "R6");
        exp_at(2, S_, mk(REL, 0, 0, 0, 0), "R6");
        exp_at(2, E_, '0, "R6");
        clm_at(2, 0, "R6");
        tick(); wait_to(cyc + 3);

        // R7: busy element refuses
        busy = 1'b1;
        rxv[W_] = mk(CLM, 0, 0, 1, 1);
        exp_at(2, W_, mk(REF, 0, 0, 0, 0), "R7");
        clm_at(2, 0, "R7");
        tick(); wait_to(cyc + 3);
        busy = 1'b0;

        // R8: zero dimension refused
        rxv[E_] = mk(CLM, 0, 1, 3, 0);
        exp_at(2, E_, mk(REF, 0, 0, 0, 0), "R8");
        clm_at(2, 0, "R8");
        tick(); wait_to(cyc + 3);
        start = 1'b1; s_dir = 2'd0; s_rows = 4'd0; s_cols = 4'd2;
        exp_at(2, L_, mk(REF, 0, 0, 0, 0), "R8");
        tick(); wait_to(cyc + 3);

        // R10: local start north-west 2x1, granted, then local release
        t = cyc;
        start = 1'b1; s_dir = 2'd3; s_rows = 4'd2; s_cols = 4'd1;
        exp_at(2, N_, mk(CLM, 1, 3, 1, 1), "R10");
        exp_at(2, W_, '0, "R10");
        clm_at(2, 1, "R10");
        wait_to(t + 4);
        rxv[N_] = mk(ACC, 0, 0, 0, 0);
        exp_at(2, L_, mk(ACC, 0, 0, 0, 0), "R10");
        tick(); wait_to(cyc + 3);
        rel = 1'b1;
        exp_at(2, N_, mk(REL, 0, 0, 0, 0), "R10");
        clm_at(2, 0, "R10");
        tick(); wait_to(cyc + 3);

        // R11: two claims, north wins, refusal to east waits one cycle
        t = cyc;
        rxv[N_] = mk(CLM, 0, 0, 1, 2);
        rxv[E_] = mk(CLM, 0, 0, 1, 1);
        exp_at(2, E_, mk(CLM, 0, 0, 1, 1), "R11");
        exp_at(3, E_, mk(REF, 0, 0, 0, 0), "R11");
        clm_at(2, 1, "R11");
        wait_to(t + 5);
        rxv[E_] = mk(ACC, 0, 0, 0, 0);
        exp_at(2, N_, mk(ACC, 0, 0, 0, 0), "R5");
        tick(); wait_to(cyc + 3);
        rxv[N_] = mk(REL, 0, 0, 0, 0);
        exp_at(2, E_, mk(REL, 0, 0, 0, 0), "R9");
        clm_at(2, 0, "R9");
        tick(); wait_to(cyc + 3);

        // R11: north and west together, no collision
        rxv[N_] = mk(CLM, 1, 0, 1, 1);
        rxv[W_] = mk(CLM, 1, 0, 1, 1);
        exp_at(2, N_, mk(ACC, 0, 0, 0, 0), "R11");
        exp_at(2, W_, mk(REF, 0, 0, 0, 0), "R11");
        clm_at(2, 1, "R11");
        tick(); wait_to(cyc + 3);
        rxv[N_] = mk(REL, 0, 0, 0, 0);
        clm_at(2, 0, "R9");
        tick(); wait_to(cyc + 4);

        mon_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule